// File: doc/BRIEF.md
# Programmable Short FIR Helper Filter

This block is a non-decimating FIR filter of one to eight taps that sits between wider filter stages as a helper. Each accepted 20-bit input sample produces exactly one 20-bit output sample. The output is computed serially, one tap per processing step, by a single multiply-accumulate unit running on the fast processing clock. Eight 6-bit signed coefficients sit in a small register bank loaded through a plain write port. Three control pins choose the filter length, turn on mirrored (symmetric) coefficient use, and select a half-rate mode in which the accumulator advances on every second clock only.

Samples enter and leave through valid/ready streams. The input side takes a sample on any edge where `s_valid` and `s_ready` are both high. `s_ready` is high only while no sample is being processed, so at most one sample is in flight. The output side holds `m_valid` and `m_data` unchanged until a rising edge with `m_ready` high. A stalled output keeps the input side closed. The control pins are sampled on the edge that accepts a sample and may change freely while that sample is being processed.

Top module: `short_fir`

## Requirements
- R1: A sample is taken on an edge with `s_valid` and `s_ready` both high. `s_ready` is high only when no sample is in flight. Each accepted sample yields exactly one output, and a sample offered while `s_ready` is low leaves the history unchanged.
- R2: `cfg_taps_m1` (3 bits) holds the filter length N minus one. The output is the sum over k = 0..N-1 of h_k times x[n-k], where x[n] is the newest accepted sample.
- R3: With `cfg_sym` = 0, h_k is coefficient register k.
- R4: With `cfg_sym` = 1, h_k is coefficient register min(k, N-1-k), so only registers 0 to ceil(N/2)-1 are read. For example, N = 5 uses 0,1,2,1,0 and N = 6 uses 0,1,2,2,1,0.
- R5: There are eight 6-bit two's-complement coefficient registers. Register `coef_addr` takes `coef_wdata` on an edge with `coef_we` high. The coefficient scale has 4 fraction bits, so the value 16 means unity gain.
- R6: The full-precision sum is rounded half up (add 8, then shift right arithmetically by 4) and then saturated to the range -524288..524287.
- R7: `m_valid` rises N clock cycles after the accepting edge, or 2N cycles with `cfg_half` = 1.
- R8: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold and `s_ready` stays low. After the edge with `m_ready` high, `m_valid` is low and `s_ready` is high.
- R9: Length, symmetry and half-rate settings are captured on the accepting edge. Changes made while a sample is in flight do not affect that sample's result or latency.
- R10: Reset (`rst_n` low, asynchronous) clears the data history and all coefficients, drives `m_valid` low and leaves `s_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_taps_m1 | input | 3 | Filter length minus one |
| cfg_sym | input | 1 | Mirror coefficients across the filter centre |
| cfg_half | input | 1 | Accumulator advances on every other clock |
| coef_we | input | 1 | Coefficient write enable |
| coef_addr | input | 3 | Coefficient register index |
| coef_wdata | input | 6 | Coefficient value, signed |
| s_valid | input | 1 | Input sample valid |
| s_ready | output | 1 | Block can take a sample |
| s_data | input | 20 | Input sample, signed |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Downstream takes the output |
| m_data | output | 20 | Output sample, signed |

## Verification
The assertions check the stream rules on every cycle. Once a sample is accepted the input closes, a stalled output holds steady, and a consumed output reopens the input. On every cycle they also check that the tap counter stays within the captured length, that half-rate mode never advances on two clocks in a row, and that symmetric mode never reads a coefficient past the middle of the filter. The arithmetic needs the bench's scenarios: impulse responses for asymmetric and symmetric lengths, rounding at the half-LSB boundary, saturation at both rails, the exact latency in each rate, and the fact that a sample offered while busy or a setting changed mid-sample has no effect.

// File: rtl/sfir_pkg.sv
package sfir_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } sfir_state_e;

  typedef struct packed {
    logic sym;
    logic half;
  } sfir_mode_t;

endpackage

// File: rtl/sfir_ctrl.sv
module sfir_ctrl
  import sfir_pkg::*;
#(
  parameter int TW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  output logic          m_valid,
  input  logic          m_ready,
  input  logic [TW-1:0] cfg_n_m1,
  input  logic          cfg_sym,
  input  logic          cfg_half,
  output logic          accept_o,
  output logic          mac_en_o,
  output logic          last_o,
  output logic [TW-1:0] tap_o,
  output logic [TW-1:0] n_m1_o,
  output logic          sym_o
);

  sfir_state_e   state_q;
  logic [TW-1:0] tap_q;
  logic [TW-1:0] n_m1_q;
  sfir_mode_t    mode_q;
  logic          phase_q;
  logic          adv;
  logic          last;

  assign s_ready  = (state_q == ST_IDLE);
  assign m_valid  = (state_q == ST_HOLD);
  assign accept_o = s_ready && s_valid;
  assign adv      = (state_q == ST_RUN) && (!mode_q.half || phase_q);
  assign last     = (tap_q == n_m1_q);
  assign mac_en_o = adv;
  assign last_o   = last;
  assign tap_o    = tap_q;
  assign n_m1_o   = n_m1_q;
  assign sym_o    = mode_q.sym;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tap_q   <= '0;
      n_m1_q  <= '0;
      mode_q  <= '0;
      phase_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (s_valid) begin
            state_q <= ST_RUN;
            tap_q   <= '0;
            phase_q <= 1'b0;
            n_m1_q  <= cfg_n_m1;
            mode_q  <= '{sym: cfg_sym, half: cfg_half};
          end
        end
        ST_RUN: begin
          phase_q <= ~phase_q;
          if (adv) begin
            if (last) state_q <= ST_HOLD;
            else      tap_q   <= tap_q + 1'b1;
          end
        end
        ST_HOLD: begin
          if (m_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: the tap index never passes the captured length
  assert_tap_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN) |-> (tap_q <= n_m1_q));

  // R7: half-rate mode never advances on two consecutive clocks
  assert_half_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && mode_q.half) |=> !adv);

endmodule

// File: rtl/sfir_hist.sv
module sfir_hist #(
  parameter int DW    = 20,
  parameter int DEPTH = 8,
  parameter int TW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_i,
  input  logic [DW-1:0] din_i,
  input  logic [TW-1:0] rd_tap_i,
  output logic [DW-1:0] rd_data_o
);

  logic [DW-1:0] taps [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [DW-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (shift_i) q <= din_i;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       q <= '0;
        else if (shift_i) q <= g_stage[i-1].q;
      end
    end
    assign taps[i] = q;
  end

  assign rd_data_o = taps[rd_tap_i];

endmodule

// File: rtl/sfir_coef.sv
module sfir_coef #(
  parameter int CW    = 6,
  parameter int NCOEF = 8,
  parameter int TW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [TW-1:0] wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic [TW-1:0] tap_i,
  input  logic [TW-1:0] n_m1_i,
  input  logic          sym_i,
  output logic [CW-1:0] coef_o
);

  logic [CW-1:0] regs [NCOEF];
  logic [TW-1:0] mirror;
  logic [TW-1:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCOEF; i++) regs[i] <= '0;
    end else if (wr_en_i) begin
      regs[wr_addr_i] <= wr_data_i;
    end
  end

  // Distance from the far end of the filter; folds the upper half back.
  assign mirror = n_m1_i - tap_i;
  assign idx    = (sym_i && (mirror < tap_i)) ? mirror : tap_i;
  assign coef_o = regs[idx];

  // R4: symmetric mode reads only the first half of the response
  assert_mirror_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sym_i |-> (idx <= (n_m1_i >> 1)));

endmodule

// File: rtl/sfir_mac.sv
module sfir_mac #(
  parameter int DW   = 20,
  parameter int CW   = 6,
  parameter int AW   = 29,
  parameter int FRAC = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          last_i,
  input  logic [DW-1:0] x_i,
  input  logic [CW-1:0] c_i,
  output logic [DW-1:0] y_o
);

  localparam int PW = DW + CW;
  localparam logic signed [AW-1:0] RND_HALF = AW'(1) <<< (FRAC - 1);
  localparam logic signed [AW-1:0] SAT_MAX =
    $signed({{(AW-DW+1){1'b0}}, {(DW-1){1'b1}}});
  localparam logic signed [AW-1:0] SAT_MIN =
    $signed({{(AW-DW+1){1'b1}}, {(DW-1){1'b0}}});

  logic signed [AW-1:0] acc_q;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] sum;
  logic signed [AW-1:0] rounded;
  logic signed [AW-1:0] scaled;
  logic        [DW-1:0] clipped;

  always_comb begin
    prod    = $signed(x_i) * $signed(c_i);
    sum     = acc_q + $signed({{(AW-PW){prod[PW-1]}}, prod});
    rounded = sum + RND_HALF;
    scaled  = rounded >>> FRAC;
    if (scaled > SAT_MAX)      clipped = SAT_MAX[DW-1:0];
    else if (scaled < SAT_MIN) clipped = SAT_MIN[DW-1:0];
    else                       clipped = scaled[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      y_o   <= '0;
    end else if (clr_i) begin
      acc_q <= '0;
    end else if (en_i) begin
      if (last_i) y_o   <= clipped;
      else        acc_q <= sum;
    end
  end

endmodule

// File: rtl/short_fir.sv
module short_fir #(
  parameter int DATA_W    = 20,
  parameter int COEF_W    = 6,
  parameter int MAX_TAPS  = 8,
  parameter int FRAC_BITS = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [$clog2(MAX_TAPS)-1:0] cfg_taps_m1,
  input  logic                       cfg_sym,
  input  logic                       cfg_half,
  input  logic                       coef_we,
  input  logic [$clog2(MAX_TAPS)-1:0] coef_addr,
  input  logic [COEF_W-1:0]          coef_wdata,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [DATA_W-1:0]          s_data,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic [DATA_W-1:0]          m_data
);

  localparam int TAP_W = $clog2(MAX_TAPS);
  localparam int ACC_W = DATA_W + COEF_W + TAP_W;

  logic             accept;
  logic             mac_en;
  logic             last;
  logic [TAP_W-1:0] tap;
  logic [TAP_W-1:0] n_m1;
  logic             sym;
  logic [DATA_W-1:0] x_tap;
  logic [COEF_W-1:0] c_tap;

  sfir_ctrl #(.TW(TAP_W)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .cfg_n_m1 (cfg_taps_m1),
    .cfg_sym  (cfg_sym),
    .cfg_half (cfg_half),
    .accept_o (accept),
    .mac_en_o (mac_en),
    .last_o   (last),
    .tap_o    (tap),
    .n_m1_o   (n_m1),
    .sym_o    (sym)
  );

  sfir_hist #(.DW(DATA_W), .DEPTH(MAX_TAPS), .TW(TAP_W)) u_hist (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_i   (accept),
    .din_i     (s_data),
    .rd_tap_i  (tap),
    .rd_data_o (x_tap)
  );

  sfir_coef #(.CW(COEF_W), .NCOEF(MAX_TAPS), .TW(TAP_W)) u_coef (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (coef_we),
    .wr_addr_i (coef_addr),
    .wr_data_i (coef_wdata),
    .tap_i     (tap),
    .n_m1_i    (n_m1),
    .sym_i     (sym),
    .coef_o    (c_tap)
  );

  sfir_mac #(.DW(DATA_W), .CW(COEF_W), .AW(ACC_W), .FRAC(FRAC_BITS)) u_mac (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (accept),
    .en_i   (mac_en),
    .last_i (last),
    .x_i    (x_tap),
    .c_i    (c_tap),
    .y_o    (m_data)
  );

  // R1: an accepted sample closes the input side
  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> !s_ready);

  // R8: a stalled output holds steady
  assert_hold_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R8: a consumed output reopens the input side
  assert_reopen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready) |=> (s_ready && !m_valid));

endmodule

// File: tb/test_short_fir.sv
`timescale 1ns/1ps
module test_short_fir;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_taps_m1 = '0;
  logic        cfg_sym = 1'b0;
  logic        cfg_half = 1'b0;
  logic        coef_we = 1'b0;
  logic [2:0]  coef_addr = '0;
  logic [5:0]  coef_wdata = '0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [19:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [19:0] m_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  short_fir i_short_fir (
    .clk, .rst_n, .cfg_taps_m1, .cfg_sym, .cfg_half,
    .coef_we, .coef_addr, .coef_wdata,
    .s_valid, .s_ready, .s_data, .m_valid, .m_ready, .m_data
  );

  typedef struct packed {
    logic [2:0]         m1;
    logic               sym;
    logic               half;
    logic signed [19:0] din;
    logic signed [19:0] dout;
  } vec_t;

  // Coefficients 16,8,-16,4,-32,31,2,-1; impulse of 1600 gives 100*h_k.
  localparam int NV = 23;
  localparam vec_t VEC [NV] = '{
    '{3'd7, 1'b0, 1'b0,  20'sd1600,  20'sd1600},
    '{3'd7, 1'b0, 1'b0,  20'sd0,     20'sd800},
    '{3'd7, 1'b0, 1'b0,  20'sd0,    -20'sd1600},
    '{3'd7, 1'b0, 1'b0,  20'sd0,     20'sd400},
    '{3'd7, 1'b0, 1'b0,  20'sd0,    -20'sd3200},
    '{3'd7, 1'b0, 1'b0,  20'sd0,     20'sd3100},
    '{3'd7, 1'b0, 1'b0,  20'sd0,     20'sd200},
    '{3'd7, 1'b0, 1'b0,  20'sd0,    -20'sd100},
    '{3'd7, 1'b0, 1'b0,  20'sd0,     20'sd0},
    '{3'd4, 1'b1, 1'b1,  20'sd1600,  20'sd1600},
    '{3'd4, 1'b1, 1'b1,  20'sd0,     20'sd800},
    '{3'd4, 1'b1, 1'b1,  20'sd0,    -20'sd1600},
    '{3'd4, 1'b1, 1'b1,  20'sd0,     20'sd800},
    '{3'd4, 1'b1, 1'b1,  20'sd0,     20'sd1600},
    '{3'd0, 1'b0, 1'b0,  20'sd0,     20'sd0},
    '{3'd0, 1'b0, 1'b0,  20'sd0,     20'sd0},
    '{3'd0, 1'b0, 1'b0,  20'sd0,     20'sd0},
    '{3'd5, 1'b1, 1'b0,  20'sd1600,  20'sd1600},
    '{3'd5, 1'b1, 1'b0,  20'sd0,     20'sd800},
    '{3'd5, 1'b1, 1'b0,  20'sd0,    -20'sd1600},
    '{3'd5, 1'b1, 1'b0,  20'sd0,    -20'sd1600},
    '{3'd5, 1'b1, 1'b0,  20'sd0,     20'sd800},
    '{3'd5, 1'b1, 1'b0,  20'sd0,     20'sd1600}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    s_valid = 1'b0;
    m_ready = 1'b1;
    coef_we = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input int addr, input int val);
    coef_addr  = addr[2:0];
    coef_wdata = val[5:0];
    coef_we    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  // Offers x at a negedge; returns at the negedge where m_valid is seen.
  task automatic send(input int x, output int y, output int lat);
    s_data  = x[19:0];
    s_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    lat = 0;
    while (!m_valid && lat < 64) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    y = $signed(m_data);
  endtask

  task automatic consume();
    m_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run1(input string req, input int x, input int exp);
    int y, lat;
    send(x, y, lat);
    check(req, y, exp);
    consume();
  endtask

  initial begin
    int y, lat;
    do_reset();

    // R10: reset state
    check("R10 m_valid after reset", int'(m_valid), 0);
    check("R10 s_ready after reset", int'(s_ready), 1);
    cfg_taps_m1 = 3'd7;
    run1("R10 coefficients cleared", 1000, 0);
    do_reset();

    // R5: load coefficients 16,8,-16,4,-32,31,2,-1
    wr(0, 16); wr(1, 8); wr(2, -16); wr(3, 4);
    wr(4, -32); wr(5, 31); wr(6, 2); wr(7, -1);

    for (int i = 0; i < NV; i++) begin
      cfg_taps_m1 = VEC[i].m1;
      cfg_sym     = VEC[i].sym;
      cfg_half    = VEC[i].half;
      check("R1 s_ready before offer", int'(s_ready), 1);
      send(int'(VEC[i].din), y, lat);
      check(VEC[i].sym ? "R4 symmetric output" : "R3 R2 asymmetric output",
            y, int'(VEC[i].dout));
      check("R7 latency", lat,
            (int'(VEC[i].m1) + 1) * (VEC[i].half ? 2 : 1));
      consume();
    end

    // R6: rounding half up with unity coefficient of 1/16
    do_reset();
    wr(0, 1);
    cfg_taps_m1 = 3'd0; cfg_sym = 1'b0; cfg_half = 1'b0;
    run1("R6 round 8/16", 8, 1);
    run1("R6 round 7/16", 7, 0);
    run1("R6 round -8/16", -8, 0);
    run1("R6 round -9/16", -9, -1);

    // R6: saturation at both rails
    wr(0, -32);
    run1("R6 saturate high", -524288, 524287);
    run1("R6 saturate low", 524287, -524288);

    // R9: settings changed mid-sample have no effect
    do_reset();
    wr(0, 16); wr(1, 16);
    cfg_taps_m1 = 3'd1; cfg_sym = 1'b0; cfg_half = 1'b1;
    s_data = 20'sd160;
    s_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    cfg_taps_m1 = 3'd7; cfg_half = 1'b0; cfg_sym = 1'b1;
    lat = 0;
    while (!m_valid && lat < 64) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
    check("R9 latency uses captured settings", lat, 4);
    check("R9 output uses captured settings", $signed(m_data), 160);
    consume();

    // R8 and R1: back-pressure, and an offer while busy is ignored
    do_reset();
    wr(0, 16); wr(1, 16);
    cfg_taps_m1 = 3'd0; cfg_sym = 1'b0; cfg_half = 1'b0;
    m_ready = 1'b0;
    send(300, y, lat);
    check("R8 stalled output value", y, 300);
    s_data = 20'sd999;
    s_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R8 m_valid held", int'(m_valid), 1);
      check("R8 m_data held", $signed(m_data), 300);
      check("R8 s_ready low while stalled", int'(s_ready), 0);
    end
    m_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    check("R8 m_valid low after take", int'(m_valid), 0);
    check("R8 s_ready high after take", int'(s_ready), 1);
    cfg_taps_m1 = 3'd1;
    run1("R1 busy offer left history unchanged", 0, 300);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule